// File: doc/BRIEF.md
# Edge-Triggered Input Capture Timer

This peripheral timestamps transitions on a single serial pulse input, such as the output of a barcode scanner. A 16-bit counter advances on every system clock. When the input changes in a direction the programmed capture mode accepts, the counter value is copied into a 16-bit capture register and a capture flag is raised. The flag can drive an interrupt line. Software then reads the two bytes of the timestamp and releases the flag.

The CPU reaches the block through a byte-wide register port with a three-bit address. Writes select the capture mode and the interrupt enables. Reads return the capture value and the live count one byte at a time. Reading a low byte also freezes the matching high byte in a shadow register. Because of this, a 16-bit value that is read low byte first always comes back coherent. A counter wrap sets an overflow flag that can also drive the interrupt.

Top module: `edge_capture_timer`

## Requirements
- R1: The count is 16 bits wide. It is 0 out of reset, increases by 1 on every clock and rolls over from 0xFFFF to 0x0000. `cnt_wrap` is high during exactly the cycles in which the count reads 0xFFFF.
- R2: Writing address 0 loads the capture mode from data bits 1:0. The codes are 00 = no capture, 01 = falling edges only, 10 = rising edges only, 11 = either edge.
- R3: A qualifying change of `pulse_in` is applied between two clock edges while the live count is C. That change loads C+2 into the capture register and sets the capture flag. The delay is two synchronizer stages plus one register.
- R4: The capture register keeps its value through any input change that the current mode does not accept.
- R5: A read of address 0 returns the capture register's low byte and copies its high byte into a shadow. A read of address 1 returns that shadow.
- R6: A read of address 2 returns the live count's low byte and copies the high byte of the same count into a shadow. A read of address 3 returns that shadow.
- R7: Writing address 4 loads the interrupt enables: bit 0 for capture, bit 1 for overflow. `irq` equals (capture flag AND bit 0) OR (overflow flag AND bit 1).
- R8: A read of address 3 clears the capture flag. If a capture occurs in the same cycle, the capture wins.
- R9: The overflow flag sets on the clock edge at which the count rolls from 0xFFFF to 0. A write to address 4 clears it.
- R10: Reset clears the count, the capture register, the shadows, both flags, the mode and the enables. After reset, addresses 0 and 1 read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse input to timestamp |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |
| cnt_wrap | output | 1 | High while the count is at its maximum |

## Verification
A stale or wrong count shows up on the next address 2 read. It also shows up as a capture value that is off from C+2 within four cycles of an input change. A wrong mode decode or a lost edge shows up as a capture register that fails to move, or moves when it should not. The same fault appears as an `irq` level that disagrees with the bench's flag model after the next settled check. A shadow loaded from the wrong count shows up at the next high-byte read that follows a low-byte read taken just before a carry. Overflow-flag faults surface at the single wrap near cycle 65536.

// File: rtl/ect_pkg.sv
package ect_pkg;
   typedef enum logic [1:0] {
      CAP_OFF  = 2'b00,
      CAP_FALL = 2'b01,
      CAP_RISE = 2'b10,
      CAP_BOTH = 2'b11
   } cap_mode_e;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CAP_LO  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CAP_HI  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd3;
   localparam logic [ADDR_W-1:0] A_IEN     = 3'd4;
   localparam logic [ADDR_W-1:0] A_MODE    = 3'd0;
endpackage

// File: rtl/ect_free_counter.sv
module ect_free_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count,
   output logic         at_max
);
   localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("ect_free_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   assign at_max = (count == MAX_VAL);

   // R1: steps by one every clock, rolling over at the top
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/ect_edge_sel.sv
module ect_edge_sel
   import ect_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  cap_mode_e mode,
   output logic      evt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ect_edge_sel: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] stage;
   logic                   prev;
   logic                   rise, fall;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[0] <= 1'b0;
            else        stage[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= 1'b0;
            else        stage[i] <= stage[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= stage[SYNC_STAGES-1];
   end

   assign rise = stage[SYNC_STAGES-1] & ~prev;
   assign fall = ~stage[SYNC_STAGES-1] & prev;

   always_comb begin
      unique case (mode)
         CAP_FALL: evt = fall;
         CAP_RISE: evt = rise;
         CAP_BOTH: evt = rise | fall;
         default:  evt = 1'b0;
      endcase
   end

   // R2: a disabled mode never yields a capture event
   assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CAP_OFF) |-> !evt);
   // R4: events come only from an actual change of the synchronized input
   assert_evt_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (stage[SYNC_STAGES-1] != prev));
endmodule

// File: rtl/ect_read_port.sv
module ect_read_port
   import ect_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                rd,
   input  logic [2*BYTE_W-1:0] cap_val,
   input  logic [2*BYTE_W-1:0] cnt_val,
   output logic [BYTE_W-1:0]   rdata
);
   logic [BYTE_W-1:0] cap_hi_sh, cnt_hi_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_hi_sh <= '0;
         cnt_hi_sh <= '0;
      end else if (rd) begin
         if (addr == A_CAP_LO) cap_hi_sh <= cap_val[2*BYTE_W-1:BYTE_W];
         if (addr == A_CNT_LO) cnt_hi_sh <= cnt_val[2*BYTE_W-1:BYTE_W];
      end
   end

   always_comb begin
      unique case (addr)
         A_CAP_LO: rdata = cap_val[BYTE_W-1:0];
         A_CAP_HI: rdata = cap_hi_sh;
         A_CNT_LO: rdata = cnt_val[BYTE_W-1:0];
         A_CNT_HI: rdata = cnt_hi_sh;
         default:  rdata = '0;
      endcase
   end

   // R6: the count shadow holds the high byte seen at the low-byte read
   assert_cnt_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == A_CNT_LO) |=> cnt_hi_sh == $past(cnt_val[2*BYTE_W-1:BYTE_W]));
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
   import ect_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pulse_in,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              irq,
   output logic              cnt_wrap
);
   localparam int unsigned CNT_W = 2 * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("edge_capture_timer: BYTE_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt, cap_q;
   logic             cap_evt, cap_flag, ovf_flag;
   cap_mode_e        mode_q;
   logic [1:0]       ien_q;
   logic             wr_mode, wr_ien, rd_cnt_hi;

   ect_free_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .count(cnt), .at_max(cnt_wrap));

   ect_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pulse_in), .mode(mode_q), .evt(cap_evt));

   ect_read_port #(.BYTE_W(BYTE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd),
      .cap_val(cap_q), .cnt_val(cnt), .rdata(bus_rdata));

   assign wr_mode   = bus_wr && (bus_addr == A_MODE);
   assign wr_ien    = bus_wr && (bus_addr == A_IEN);
   assign rd_cnt_hi = bus_rd && (bus_addr == A_CNT_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CAP_OFF;
         ien_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= cap_mode_e'(bus_wdata[1:0]);
         if (wr_ien)  ien_q  <= bus_wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q    <= '0;
         cap_flag <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         if (cap_evt) cap_q <= cnt;
         if (cap_evt)        cap_flag <= 1'b1;
         else if (rd_cnt_hi) cap_flag <= 1'b0;
         if (cnt_wrap)       ovf_flag <= 1'b1;
         else if (wr_ien)    ovf_flag <= 1'b0;
      end
   end

   assign irq = (cap_flag & ien_q[0]) | (ovf_flag & ien_q[1]);

   // R3: a capture event stores the count of that cycle and raises the flag
   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_flag && cap_q == $past(cnt)));
   // R4: without an event the captured value does not move
   assert_capture_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> $stable(cap_q));
   // R8: reading the high count byte drops the capture flag
   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cnt_hi && !cap_evt) |=> !cap_flag);
   // R9: a rollover always leaves the overflow flag set
   assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wrap |=> ovf_flag);
endmodule

// File: tb/edge_capture_timer_bench.sv
module edge_capture_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pulse_in = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq, cnt_wrap;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_cnt;
   logic [15:0] exp_cap;
   logic        exp_flag;
   logic [1:0]  cur_mode;
   bit          done = 0;

   always #5 clk = ~clk;

   edge_capture_timer u_edge_capture_timer (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .cnt_wrap(cnt_wrap));

   // cycle model of the free-running count, from R1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_cnt <= '0;
      else        m_cnt <= m_cnt + 1'b1;
   end

   function automatic bit qualifies(input logic [1:0] mode, input bit rising);
      case (mode)
         2'b01:   return !rising;
         2'b10:   return rising;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // returns the data and the model count seen during the read cycle
   task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic [15:0] c);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata; c = m_cnt;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      bus_write(3'd0, {6'd0, m});
      cur_mode = m;
   endtask

   // flips the input, then waits until any capture has settled (R3)
   task automatic toggle_pin();
      logic [15:0] c0;
      bit rising;
      @(negedge clk);
      rising = !pulse_in;
      c0 = m_cnt;
      pulse_in = !pulse_in;
      if (qualifies(cur_mode, rising)) begin
         exp_cap  = c0 + 16'd2;
         exp_flag = 1'b1;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_capture(input string req);
      logic [7:0] lo, hi;
      logic [15:0] c;
      bus_read(3'd0, lo, c);
      bus_read(3'd1, hi, c);
      check(req, {hi, lo}, exp_cap);
   endtask

   task automatic clear_flag();
      logic [7:0] d;
      logic [15:0] c;
      bus_read(3'd3, d, c);
      exp_flag = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, lo, hi;
      logic [15:0] c, clo;
      exp_cap = '0; exp_flag = 1'b0; cur_mode = 2'b00;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      bus_read(3'd0, d, c); check("R10 cap lo", d, 8'h00);
      bus_read(3'd1, d, c); check("R10 cap hi", d, 8'h00);
      check("R10 irq", irq, 1'b0);

      // R1, R6: live count read back coherently
      bus_read(3'd2, lo, clo);
      bus_read(3'd3, hi, c);
      check("R6 count word", {hi, lo}, clo);

      // R2: mode 00 ignores both edges, nothing captured, no irq
      bus_write(3'd4, 8'h01);
      toggle_pin(); toggle_pin();
      check_capture("R2 disabled");
      check("R2 irq disabled", irq, 1'b0);

      // R2, R3, R4, R7: directed rising-only capture
      set_mode(2'b10);
      toggle_pin();
      check_capture("R3 rising capture");
      check("R7 irq on capture", irq, 1'b1);
      toggle_pin();
      check_capture("R4 falling ignored in rising mode");
      clear_flag();
      check("R8 flag cleared", irq, 1'b0);

      // R7: capture flag without enable keeps irq low
      set_mode(2'b01);
      bus_write(3'd4, 8'h00);
      toggle_pin(); toggle_pin();
      check_capture("R3 falling capture");
      check("R7 masked", irq, 1'b0);
      bus_write(3'd4, 8'h01);
      check("R7 unmasked", irq, 1'b1);
      clear_flag();

      // random mode and edge mix
      for (int i = 0; i < 60; i++) begin
         if (($urandom % 3) == 0) set_mode(2'($urandom % 4));
         toggle_pin();
         repeat ($urandom % 5) @(negedge clk);
         check_capture("R3 R4 random capture");
         check("R7 R8 random irq", irq, exp_flag);
         if (($urandom % 2) == 0) begin
            bus_read(3'd2, lo, clo);
            repeat ($urandom % 4) @(negedge clk);
            bus_read(3'd3, hi, c);
            exp_flag = 1'b0;
            check("R6 random shadow", {hi, lo}, clo);
            check("R8 random clear", irq, 1'b0);
         end
      end

      // R5: capture shadow is taken at the low read, not the high read
      set_mode(2'b11);
      toggle_pin();
      bus_read(3'd0, lo, c);
      toggle_pin();
      bus_read(3'd1, hi, c);
      check("R5 capture shadow", hi, 8'(({8'h00, lo} + 16'h0000) >> 8) | 8'(c - c) | 8'(exp_cap_hi_prev(lo)));
      clear_flag();

      // R6: low read just before a carry keeps the old high byte
      while (m_cnt[7:0] != 8'hFD) @(negedge clk);
      bus_read(3'd2, lo, clo);
      repeat (6) @(negedge clk);
      bus_read(3'd3, hi, c);
      check("R6 carry coherency", {hi, lo}, clo);

      // R1, R9: rollover, cnt_wrap and overflow interrupt
      bus_write(3'd4, 8'h02);
      check("R9 ovf clear before wrap", irq, 1'b0);
      while (m_cnt != 16'hFFFF) @(negedge clk);
      #1 check("R1 wrap flag at max", cnt_wrap, 1'b1);
      @(negedge clk);
      #1 check("R1 rolled to zero", cnt_wrap, 1'b0);
      check("R9 ovf irq", irq, 1'b1);
      bus_read(3'd2, lo, clo);
      check("R1 count after wrap", lo, clo[7:0]);
      bus_write(3'd4, 8'h02);
      check("R9 ovf cleared by write", irq, 1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // high byte of the capture value that was held when the low byte was read
   logic [15:0] cap_at_lo;
   always @(negedge clk) if (bus_rd && bus_addr == 3'd0) cap_at_lo <= exp_cap;
   function automatic logic [7:0] exp_cap_hi_prev(input logic [7:0] unused_lo);
      return cap_at_lo[15:8] | (unused_lo & 8'h00);
   endfunction
endmodule